// File: doc/BRIEF.md
# Integer ALU With Status Flags

This block is the integer execution slice of a processor datapath. In one clock it adds, subtracts (with or without an incoming carry or borrow), applies a bitwise AND, OR or XOR, compares, tests, or shifts. It can work on 8, 16 or 32 bits, and it keeps four status flags: carry, zero, overflow and sign. Operand `a` is also the old value of the destination. A narrow operation therefore replaces only the low byte or low halfword of that value, and the bits above the active width are passed through unchanged.

The carry fed into add-with-carry and subtract-with-borrow comes from a port, which normally carries the stored carry flag back in. Compare and test only set the flags; they never assert the write strobe. Subtraction treats carry as a borrow. Overflow is the carry into the active sign bit XORed with the carry out of it, so one adder serves signed and unsigned operands. All results and flags are registered. The outputs change on the clock edge that follows an enabled operation.

Top module: `alu_flags_unit`

## Requirements
- R1: With `op_i` ADD=0, ADC=1, SUB=2 or SBB=3, the written result is a+b+c or a-b-c modulo 2^n. Here n is the active width and c is `cf_in_i` for ADC and SBB and 0 for ADD and SUB.
- R2: After an add, `cf_o` is the carry out of bit n-1. After a subtract or compare (CMP=7), `cf_o` is 1 exactly when a borrow occurs, that is when b (+c) exceeds a as unsigned n-bit values.
- R3: Whenever flags are updated, `zf_o` is 1 exactly when the n-bit result is zero, and `sf_o` is bit n-1 of that result.
- R4: After an arithmetic operation, `of_o` is 1 exactly when the signed n-bit result falls outside the signed n-bit range. This equals the carry into bit n-1 XOR the carry out of bit n-1.
- R5: CMP (7) updates the flags as SUB does, and TEST (8) updates the flags as AND does. Neither one asserts `wr_o`, and `res_o` keeps its previous value.
- R6: AND=4, OR=5, XOR=6 and TEST write the bitwise result (TEST writes no result) and clear `cf_o` and `of_o`.
- R7: SHL=9 shifts left and fills with zeros. SHR=10 shifts right and fills with zeros. SAR=11 shifts right and fills with copies of bit n-1. `cf_o` is the last bit shifted out: for a left shift this is bit n of the widened value, for right shifts it is operand bit c-1, and past the width it is 0 for SHL and SHR and the sign for SAR. `of_o` is cleared.
- R8: The shift count is 1 when `cnt_one_i` is high and `b_i[4:0]` otherwise, so bits above 4 are ignored. A count of 0 writes nothing and leaves all flags unchanged.
- R9: `size_i` 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 select 32 bits. On a write, `res_o` bits above n-1 equal the same bits of `a_i`.
- R10: Results and flags appear one clock after `en_i` is sampled high. While `en_i` is low, `wr_o` is 0 and `res_o` and all flags hold.
- R11: Asynchronous reset clears `res_o`, `wr_o` and all four flags.
- R12: Op codes 12 to 15 write nothing and leave the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| en_i | input | 1 | Operation valid this cycle |
| op_i | input | 4 | Operation code |
| size_i | input | 2 | Operand width select |
| a_i | input | DW | First operand and old destination value |
| b_i | input | DW | Second operand; low 5 bits give the shift count |
| cnt_one_i | input | 1 | Shift by exactly one position |
| cf_in_i | input | 1 | Carry or borrow input for ADC and SBB |
| res_o | output | DW | Registered result |
| wr_o | output | 1 | Result was written this cycle |
| cf_o | output | 1 | Carry / borrow flag |
| zf_o | output | 1 | Zero flag |
| of_o | output | 1 | Signed overflow flag |
| sf_o | output | 1 | Sign flag |

## Verification
All outputs come from one register stage, so every result, strobe and flag for an operation is due on the first rising edge after the operation is presented. The bench drives each operation on a falling edge and compares the outputs at the next falling edge, half a period after they update. Operations that must hold state (count-zero shifts, unknown op codes, idle cycles) are checked in that same slot against the value the bench expects from the previous operation.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBB  = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_CMP  = 4'd7,
    OP_TEST = 4'd8,
    OP_SHL  = 4'd9,
    OP_SHR  = 4'd10,
    OP_SAR  = 4'd11
  } alu_op_e;

  typedef enum logic [1:0] {
    SHK_LEFT  = 2'd0,
    SHK_LOGIC = 2'd1,
    SHK_ARITH = 2'd2
  } shift_kind_e;

  typedef struct packed {
    logic cf;
    logic zf;
    logic of;
    logic sf;
  } alu_flags_t;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int DW = 32,
  localparam int CW = $clog2(DW)
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [DW-1:0] mask_i,
  input  logic [CW-1:0] msb_i,
  input  logic          sub_i,
  input  logic          bin_i,
  output logic [DW-1:0] sum_o,
  output logic          cf_o,
  output logic          of_o
);
  logic [DW-1:0] bx;
  logic [DW:0]   s;
  logic          c0, cout, csign;

  always_comb begin
    bx    = (sub_i ? ~b_i : b_i) & mask_i;
    c0    = sub_i ? ~bin_i : bin_i;
    s     = {1'b0, a_i} + {1'b0, bx} + {{DW{1'b0}}, c0};
    cout  = s[int'(msb_i) + 1];
    csign = s[msb_i] ^ a_i[msb_i] ^ bx[msb_i];
    sum_o = s[DW-1:0];
    of_o  = csign ^ cout;
    cf_o  = sub_i ? ~cout : cout;
  end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter
  import alu_flags_pkg::*;
#(
  parameter int DW = 32,
  localparam int CW = $clog2(DW),
  localparam int W2 = 2 * DW
) (
  input  logic [DW-1:0] a_i,
  input  logic [CW-1:0] msb_i,
  input  logic [CW-1:0] cnt_i,
  input  shift_kind_e   kind_i,
  output logic [DW-1:0] res_o,
  output logic          cf_o
);
  logic [W2-1:0] lft, hmask, ext;
  logic [W2:0]   rgt;

  always_comb begin
    lft   = {{DW{1'b0}}, a_i} << cnt_i;
    hmask = ({W2{1'b1}} << msb_i) << 1;
    ext   = {{DW{1'b0}}, a_i};
    if (kind_i == SHK_ARITH && a_i[msb_i]) ext = ext | hmask;
    rgt   = {ext, 1'b0} >> cnt_i;
    if (kind_i == SHK_LEFT) begin
      res_o = lft[DW-1:0];
      cf_o  = lft[int'(msb_i) + 1];
    end else begin
      res_o = rgt[DW:1];
      cf_o  = rgt[0];
    end
  end
endmodule

// File: rtl/alu_flags_unit.sv
module alu_flags_unit
  import alu_flags_pkg::*;
#(
  parameter int DW = 32,
  localparam int CW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic [3:0]    op_i,
  input  logic [1:0]    size_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          cnt_one_i,
  input  logic          cf_in_i,
  output logic [DW-1:0] res_o,
  output logic          wr_o,
  output logic          cf_o,
  output logic          zf_o,
  output logic          of_o,
  output logic          sf_o
);
  logic [CW-1:0] msb, cnt;
  logic [DW-1:0] mask, am, bm, r, sum, sh_res, res_d;
  logic          sub, bin, add_cf, add_of, sh_cf, wr_d, upd_d;
  shift_kind_e   kind;
  alu_flags_t    flg_d, flg_q;
  logic [DW-1:0] res_q;
  logic          wr_q;

  always_comb begin
    case (size_i)
      2'd0:    msb = CW'(7);
      2'd1:    msb = CW'(15);
      default: msb = CW'(DW - 1);
    endcase
    mask = ~(({DW{1'b1}} << msb) << 1);
    am   = a_i & mask;
    bm   = b_i & mask;
    cnt  = cnt_one_i ? CW'(1) : b_i[CW-1:0];
    sub  = (op_i == OP_SUB) || (op_i == OP_SBB) || (op_i == OP_CMP);
    bin  = ((op_i == OP_ADC) || (op_i == OP_SBB)) && cf_in_i;
    case (op_i)
      OP_SHR:  kind = SHK_LOGIC;
      OP_SAR:  kind = SHK_ARITH;
      default: kind = SHK_LEFT;
    endcase
  end

  alu_addsub #(.DW(DW)) i_addsub (
    .a_i(am), .b_i(bm), .mask_i(mask), .msb_i(msb), .sub_i(sub), .bin_i(bin),
    .sum_o(sum), .cf_o(add_cf), .of_o(add_of)
  );

  alu_shifter #(.DW(DW)) i_shifter (
    .a_i(am), .msb_i(msb), .cnt_i(cnt), .kind_i(kind),
    .res_o(sh_res), .cf_o(sh_cf)
  );

  always_comb begin
    r        = '0;
    wr_d     = 1'b1;
    upd_d    = 1'b1;
    flg_d    = flg_q;
    flg_d.cf = 1'b0;
    flg_d.of = 1'b0;
    case (op_i)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_CMP: begin
        r        = sum;
        flg_d.cf = add_cf;
        flg_d.of = add_of;
        wr_d     = (op_i != OP_CMP);
      end
      OP_AND, OP_TEST: begin
        r    = am & bm;
        wr_d = (op_i != OP_TEST);
      end
      OP_OR:  r = am | bm;
      OP_XOR: r = am ^ bm;
      OP_SHL, OP_SHR, OP_SAR: begin
        r        = sh_res;
        flg_d.cf = sh_cf;
        if (cnt == '0) begin
          wr_d  = 1'b0;
          upd_d = 1'b0;
        end
      end
      default: begin
        wr_d  = 1'b0;
        upd_d = 1'b0;
      end
    endcase
    r        = r & mask;
    flg_d.zf = (r == '0);
    flg_d.sf = r[msb];
    res_d    = (a_i & ~mask) | r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      wr_q  <= 1'b0;
      flg_q <= '0;
    end else begin
      wr_q <= en_i && wr_d;
      if (en_i && wr_d)  res_q <= res_d;
      if (en_i && upd_d) flg_q <= flg_d;
    end
  end

  assign res_o = res_q;
  assign wr_o  = wr_q;
  assign cf_o  = flg_q.cf;
  assign zf_o  = flg_q.zf;
  assign of_o  = flg_q.of;
  assign sf_o  = flg_q.sf;
endmodule

// File: rtl/alu_flags_checker.sv
module alu_flags_checker #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en_i,
  input logic [3:0]    op_i,
  input logic [1:0]    size_i,
  input logic [DW-1:0] a_i,
  input logic [DW-1:0] res_o,
  input logic          wr_o,
  input logic          cf_o,
  input logic          zf_o,
  input logic          of_o,
  input logic          sf_o
);
  logic [1:0] size_q;
  logic [DW-1:0] wmask;
  int unsigned   wmsb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) size_q <= 2'd0;
    else        size_q <= size_i;
  end

  always_comb begin
    wmsb  = (size_q == 2'd0) ? 7 : (size_q == 2'd1) ? 15 : DW - 1;
    wmask = ~(({DW{1'b1}} << wmsb) << 1);
  end

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (!wr_o && $stable(res_o) && $stable({cf_o, zf_o, of_o, sf_o})));

  a_r5_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && (op_i == 4'd7 || op_i == 4'd8)) |=> (!wr_o && $stable(res_o)));

  a_r6_logic_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && op_i >= 4'd4 && op_i <= 4'd6) |=> (!cf_o && !of_o));

  a_r3_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    wr_o |-> (zf_o == ((res_o & wmask) == '0)));

  a_r3_sign_flag: assert property (@(posedge clk) disable iff (!rst_n)
    wr_o |-> (sf_o == res_o[wmsb]));

  a_r9_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && size_i == 2'd0) |=> (!wr_o || res_o[DW-1:8] == $past(a_i[DW-1:8])));

  a_r12_unknown_op: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && op_i >= 4'd12) |=> (!wr_o && $stable({cf_o, zf_o, of_o, sf_o})));
endmodule

bind alu_flags_unit alu_flags_checker #(.DW(DW)) i_alu_flags_checker (
  .clk(clk), .rst_n(rst_n), .en_i(en_i), .op_i(op_i), .size_i(size_i),
  .a_i(a_i), .res_o(res_o), .wr_o(wr_o), .cf_o(cf_o), .zf_o(zf_o),
  .of_o(of_o), .sf_o(sf_o)
);

// File: tb/test_alu_flags_unit.sv
`timescale 1ns/100ps
module test_alu_flags_unit;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          en_i;
  logic [3:0]    op_i;
  logic [1:0]    size_i;
  logic [DW-1:0] a_i, b_i;
  logic          cnt_one_i, cf_in_i;
  logic [DW-1:0] res_o;
  logic          wr_o, cf_o, zf_o, of_o, sf_o;

  int checks = 0;
  int errors = 0;

  logic [DW-1:0] e_res = '0;
  logic          e_wr = 1'b0;
  logic [3:0]    e_flg = 4'b0;

  always #2.5 clk = ~clk;

  alu_flags_unit #(.DW(DW)) i_alu_flags_unit (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .op_i(op_i), .size_i(size_i),
    .a_i(a_i), .b_i(b_i), .cnt_one_i(cnt_one_i), .cf_in_i(cf_in_i),
    .res_o(res_o), .wr_o(wr_o), .cf_o(cf_o), .zf_o(zf_o), .of_o(of_o), .sf_o(sf_o)
  );

  // Reference model: updates e_res, e_wr, e_flg {cf,zf,of,sf}
  task automatic model(input int op, input int sz, input logic [31:0] a,
                       input logic [31:0] b, input bit c, input bit one);
    int n;
    longint m, half, an, bn, sa, sb, s, ss, r, cin;
    bit cf, of, wr, upd;
    int cnt;
    n    = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
    m    = (longint'(1) << n) - 1;
    half = longint'(1) << (n - 1);
    an   = longint'(a) & m;
    bn   = longint'(b) & m;
    sa   = (an >= half) ? an - 2 * half : an;
    sb   = (bn >= half) ? bn - 2 * half : bn;
    cin  = (op == 1 || op == 3) ? longint'(c) : 0;
    cnt  = one ? 1 : int'(b & 32'd31);
    wr = 1; upd = 1; cf = 0; of = 0; r = 0;
    case (op)
      0, 1: begin
        s = an + bn + cin; r = s & m; cf = (s > m);
        ss = sa + sb + cin; of = (ss > half - 1) || (ss < -half);
      end
      2, 3, 7: begin
        s = an - bn - cin; r = s & m; cf = (s < 0);
        ss = sa - sb - cin; of = (ss > half - 1) || (ss < -half);
        wr = (op != 7);
      end
      4, 8: begin r = an & bn; wr = (op != 8); end
      5: r = an | bn;
      6: r = an ^ bn;
      9, 10, 11: begin
        if (cnt == 0) begin wr = 0; upd = 0; end
        else if (op == 9) begin
          s = an << cnt; r = s & m; cf = s[n];
        end else if (op == 10) begin
          r = an >> cnt; s = an >> (cnt - 1); cf = s[0];
        end else begin
          r = (sa >>> cnt) & m; s = sa >>> (cnt - 1); cf = s[0];
        end
      end
      default: begin wr = 0; upd = 0; end
    endcase
    e_wr = wr;
    if (wr) e_res = (a & ~32'(m)) | 32'(r);
    if (upd) e_flg = {cf, (r == 0), of, r[n-1]};
  endtask

  task automatic compare(input string tag);
    checks++;
    if ({res_o, wr_o, cf_o, zf_o, of_o, sf_o} !== {e_res, e_wr, e_flg}) begin
      errors++;
      $display("FAIL %s: got res=%h wr=%b cf/zf/of/sf=%b%b%b%b expected res=%h wr=%b flags=%b",
               tag, res_o, wr_o, cf_o, zf_o, of_o, sf_o, e_res, e_wr, e_flg);
    end
  endtask

  // drive on a falling edge, outputs due on next rising edge, compared on next falling edge
  task automatic run(input int op, input int sz, input logic [31:0] a,
                     input logic [31:0] b, input bit c, input bit one, input string tag);
    en_i = 1'b1; op_i = 4'(op); size_i = 2'(sz);
    a_i = a; b_i = b; cf_in_i = c; cnt_one_i = one;
    model(op, sz, a, b, c, one);
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  function automatic string op_tag(input int op);
    case (op)
      0, 1, 2, 3: return "R1 R2 R3 R4";
      7:          return "R5 R2 R4";
      8:          return "R5 R6";
      4, 5, 6:    return "R6 R3";
      default:    return "R7 R8 R3";
    endcase
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got no end expected end before timeout");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; en_i = 1'b0; op_i = '0; size_i = '0;
    a_i = '0; b_i = '0; cnt_one_i = 1'b0; cf_in_i = 1'b0;
    repeat (3) @(negedge clk);
    compare("R11 reset");
    rst_n = 1'b1;
    @(negedge clk);

    // 8-bit sweep over arithmetic and logic ops
    for (int op = 0; op <= 8; op++)
      for (int a = 0; a < 256; a += 5)
        for (int b = 0; b < 256; b += 3)
          run(op, 0, 32'hA5C3_0000 | 32'(a), 32'h5A00_0000 | 32'(b),
              1'((a ^ b) & 1), 1'b0, {op_tag(op), " R9"});

    // 8-bit shifts, every value and count (count in b[4:0], upper b bits set: R8)
    for (int op = 9; op <= 11; op++)
      for (int a = 0; a < 256; a++)
        for (int k = 0; k < 32; k++)
          run(op, 0, 32'h1234_5600 | 32'(a), 32'hFFFF_FFE0 | 32'(k), 1'b0, 1'b0, "R7 R8 R9");

    // shift by one selected by cnt_one_i regardless of b
    for (int op = 9; op <= 11; op++)
      for (int a = 0; a < 256; a++)
        run(op, 0, 32'(a), 32'h0000_0000, 1'b0, 1'b1, "R8 R7");

    // 16 and 32 bit widths, size code 3 also 32 bits
    for (int sz = 1; sz <= 3; sz++)
      for (int op = 0; op <= 11; op++)
        for (int i = 0; i < 250; i++)
          run(op, sz, $urandom, (i < 20) ? 32'(i) : $urandom, 1'(i & 1), 1'b0,
              {op_tag(op), " R9"});

    // boundary cases at 32 bits
    run(0, 2, 32'hFFFF_FFFF, 32'h1, 1'b0, 1'b0, "R2 R3 carry wrap to zero");
    run(0, 2, 32'h7FFF_FFFF, 32'h1, 1'b0, 1'b0, "R4 positive overflow");
    run(2, 2, 32'h0, 32'h1, 1'b0, 1'b0, "R2 borrow");
    run(2, 2, 32'h8000_0000, 32'h1, 1'b0, 1'b0, "R4 negative overflow");
    run(1, 2, 32'hFFFF_FFFF, 32'h0, 1'b1, 1'b0, "R1 carry in");
    run(3, 2, 32'h0, 32'h0, 1'b1, 1'b0, "R1 borrow in");
    run(7, 2, 32'h5, 32'h5, 1'b0, 1'b0, "R5 equal compare");
    run(11, 2, 32'h8000_0000, 32'd31, 1'b0, 1'b0, "R7 arithmetic fill");
    run(9, 2, 32'h8000_0001, 32'd0, 1'b0, 1'b0, "R8 count zero keeps state");

    // unknown op codes
    for (int op = 12; op <= 15; op++)
      run(op, 2, 32'hFFFF_FFFF, 32'h0, 1'b1, 1'b0, "R12 unknown op");

    // idle cycles hold everything
    run(0, 2, 32'h8000_0000, 32'h8000_0000, 1'b0, 1'b0, "R4 R2 setup");
    en_i = 1'b0; op_i = 4'd0; a_i = 32'h1; b_i = 32'h1;
    e_wr = 1'b0;
    @(posedge clk);
    @(negedge clk);
    compare("R10 idle hold");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule